// File: doc/BRIEF.md
# Banked SRAM Address Latch Sequencer

This block sits between byte-oriented requesters and a pair of external SRAM chips. The chips share an address held in three external byte-wide latches. A request names one of four access contexts, an operation, a size (1, 2 or 4 bytes), a 20-bit flat byte address and write data. The block turns each byte of the transfer into a short run of latch-load cycles followed by one access cycle. Bit 19 of the address picks which chip is enabled, and bits 18:0 go into the latches. Multi-byte values move lowest address first, with byte k of the data bus belonging to address+k.

The block keeps a copy of what each external latch currently holds. Before each byte it reloads only the latches whose value would change. A run of sequential bytes therefore usually costs one low-byte load plus the access, and a carry costs one or two more loads. Each context remembers its own running address. When several users interleave sequential streams, each stream picks up at its own next byte. Any latch bytes that another user disturbed are detected by the comparison and written back. Setting a context's address discards the latch copy for that context's next transfer, so that transfer rewrites all three latches.

Top module: `sram_latch_seq`

## Requirements
- R1: During and after reset the block is idle. req_ready is 1, lat_ld is 0, lat_data is 0, sram_ce_n is 2'b11, sram_oe_n and sram_we_n are 1, sram_dout_en is 0, sram_dout is 0 and rd_valid is 0. Every context address is 0, and the first transfer after reset loads all three latches.
- R2: On an access cycle, address bit 19 = 0 drives sram_ce_n = 2'b10 and bit 19 = 1 drives sram_ce_n = 2'b01. The low latch carries address bits 7:0, the middle latch bits 15:8, and the high latch {5'b0, bits 18:16}.
- R3: Each byte is preceded by latch loads, one per cycle in the order low (lat_ld = 3'b001), middle (3'b010), high (3'b100), with lat_data holding the byte. A latch is loaded only if it has never been loaded since reset or invalidation, or if its required value differs from what was last loaded. After the loads comes exactly one access cycle.
- R4: req_op = 0 (set) stores req_addr as the address of context req_ctx. It is accepted in one cycle with no SRAM activity. The next sequential transfer of that context reloads all three latches, even when their values already match.
- R5: req_op = 2 (sequential) starts at the context's stored address and advances it by one after each byte. The address wraps from 0xFFFFF to 0x00000.
- R6: The four contexts are independent. A context's stored address changes only through its own set or sequential operations, so interleaved streams resume where they left off.
- R7: req_op = 1 (random) transfers starting at req_addr, with the address advancing per byte, and changes no context address.
- R8: req_size 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 move 4 bytes. Byte k (address + k) is req_wdata[8k+7:8k] on writes and rd_data[8k+7:8k] on reads.
- R9: On a write access cycle, sram_we_n = 0, sram_dout_en = 1 and sram_dout carries the byte. On a read access cycle, sram_oe_n = 0 and sram_din is captured at the end of that cycle.
- R10: After the last access of a read, rd_valid is 1 for exactly one cycle with rd_data holding the bytes read and unused upper bytes 0. Writes produce no rd_valid.
- R11: req_op = 3 is accepted with no SRAM activity and leaves context addresses and the latch copy unchanged.
- R12: req_ready is 0 from the cycle after a random or sequential request is accepted until its last access cycle ends. A request is taken only when req_valid and req_ready are both 1.
- R13: Outside a load cycle lat_data is 0. Outside a write access cycle sram_dout is 0 and sram_dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_ctx | input | 2 | Context index |
| req_op | input | 2 | 0 set, 1 random, 2 sequential, 3 no operation |
| req_wr | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| req_addr | input | 20 | Flat byte address |
| req_wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 32 | Read result, little-endian |
| lat_data | output | 8 | Byte presented to the external latches |
| lat_ld | output | 3 | Load strobes: bit 0 low, bit 1 middle, bit 2 high |
| sram_ce_n | output | 2 | Active-low chip selects, one per chip |
| sram_oe_n | output | 1 | Active-low read strobe |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_dout | output | 8 | Data to SRAM |
| sram_dout_en | output | 1 | Data bus drive enable |
| sram_din | input | 8 | Data from SRAM |

## Verification
The first random write starts from cold latches, and the repeated random read of the same address then differs from it only in low-byte loads. Together they separate the "never loaded" rule from the "value differs" rule. A sequential stream across 0x7FFFF/0x80000 and another across 0xFFFFF/0x00000 exercise carries into the middle and high latches, the chip-select flip and the address wrap. Two contexts interleave with random accesses and a no-op between their sequential steps, which shows that each stream resumes at its own address and rewrites only the disturbed latches. A set onto an address whose latch values already match confirms that the forced full reload comes from the set itself and not from the comparison.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;
   typedef enum logic [1:0] {
      OP_SET  = 2'd0,
      OP_RAND = 2'd1,
      OP_SEQ  = 2'd2,
      OP_NOP  = 2'd3
   } op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_st_e;
endpackage

// File: rtl/sram_addr_map.sv
`timescale 1ns/1ps
module sram_addr_map #(
   parameter int ADDR_W = 20,
   parameter int LAT_W  = 8,
   parameter int N_LAT  = 3
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic [N_LAT*LAT_W-1:0]  lat_flat,
   output logic                    chip
);
   localparam int PHYS_W = ADDR_W - 1;
   localparam int FLAT_W = N_LAT * LAT_W;
   localparam int PAD_W  = FLAT_W - PHYS_W;

   if (PAD_W < 0) begin : g_bad_map
      $error("latches too narrow for the physical address");
   end else if (PAD_W == 0) begin : g_exact
      assign lat_flat = addr[PHYS_W-1:0];
   end else begin : g_pad
      assign lat_flat = {{PAD_W{1'b0}}, addr[PHYS_W-1:0]};
   end

   assign chip = addr[ADDR_W-1];
endmodule

// File: rtl/sram_latch_shadow.sv
`timescale 1ns/1ps
module sram_latch_shadow #(
   parameter int LAT_W = 8,
   parameter int N_LAT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_LAT*LAT_W-1:0]  want,
   input  logic                    inval,
   input  logic                    ld_en,
   output logic [N_LAT-1:0]        ld_pick,
   output logic                    any_need
);
   logic [N_LAT-1:0] need;

   for (genvar i = 0; i < N_LAT; i++) begin : g_lat
      logic [LAT_W-1:0] held_q;
      logic             ok_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held_q <= '0;
            ok_q   <= 1'b0;
         end else if (inval) begin
            ok_q   <= 1'b0;
         end else if (ld_en && ld_pick[i]) begin
            held_q <= want[i*LAT_W +: LAT_W];
            ok_q   <= 1'b1;
         end
      end

      assign need[i] = !ok_q || (held_q != want[i*LAT_W +: LAT_W]);

      // a latch just written is satisfied on the following cycle
      assert_load_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_en && ld_pick[i] && !inval) |=> !need[i] || !$stable(want));
   end

   assign ld_pick  = need & (~need + N_LAT'(1));
   assign any_need = |need;
endmodule

// File: rtl/sram_ctx_file.sv
`timescale 1ns/1ps
module sram_ctx_file #(
   parameter int ADDR_W = 20,
   parameter int N_CTX  = 4,
   parameter int CTX_W  = $clog2(N_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [CTX_W-1:0]  set_ctx,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic              upd_en,
   input  logic [CTX_W-1:0]  upd_ctx,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              clr_en,
   input  logic [CTX_W-1:0]  rd_ctx,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_force
);
   logic [ADDR_W-1:0] addr_v  [N_CTX];
   logic              force_v [N_CTX];

   for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      logic [ADDR_W-1:0] a_q;
      logic              f_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            a_q <= '0;
            f_q <= 1'b1;
         end else if (set_en && set_ctx == CTX_W'(c)) begin
            a_q <= set_addr;
            f_q <= 1'b1;
         end else begin
            if (upd_en && upd_ctx == CTX_W'(c)) a_q <= upd_addr;
            if (clr_en && rd_ctx == CTX_W'(c))  f_q <= 1'b0;
         end
      end

      assign addr_v[c]  = a_q;
      assign force_v[c] = f_q;
   end

   assign rd_addr  = addr_v[rd_ctx];
   assign rd_force = force_v[rd_ctx];
endmodule

// File: rtl/sram_latch_seq.sv
`timescale 1ns/1ps
module sram_latch_seq
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int N_CTX      = 4,
   parameter int N_LAT      = 3,
   parameter int LAT_W      = 8,
   parameter int DATA_BYTES = 4,
   localparam int CTX_W     = $clog2(N_CTX),
   localparam int DATA_W    = 8 * DATA_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [1:0]        req_op,
   input  logic              req_wr,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [LAT_W-1:0]  lat_data,
   output logic [N_LAT-1:0]  lat_ld,
   output logic [1:0]        sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [7:0]        sram_dout,
   output logic              sram_dout_en,
   input  logic [7:0]        sram_din
);
   localparam int CNT_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

   if (N_CTX < 2) begin : g_bad_ctx
      $error("at least two contexts are required");
   end
   if (DATA_BYTES < 2 || DATA_BYTES > 8) begin : g_bad_bytes
      $error("DATA_BYTES must lie in 2..8");
   end

   function automatic logic [CNT_W-1:0] last_of(input logic [1:0] sz);
      int n;
      n = 1 << sz;
      if (n > DATA_BYTES) n = DATA_BYTES;
      return CNT_W'(n - 1);
   endfunction

   seq_st_e            st_q;
   logic               seq_q, wr_q;
   logic [CTX_W-1:0]   ctx_q;
   logic [ADDR_W-1:0]  cur_q;
   logic [CNT_W-1:0]   cnt_q, last_q;
   logic [DATA_W-1:0]  wd_q, rbuf_q, rbuf_nx;

   logic                    take, start_xfer, start_seq, set_req;
   logic [ADDR_W-1:0]       ctx_addr;
   logic                    ctx_force;
   logic [N_LAT*LAT_W-1:0]  want;
   logic                    chip;
   logic [N_LAT-1:0]        ld_pick;
   logic                    any_need, running, acc_cyc;

   assign take       = (st_q == ST_IDLE) && req_valid;
   assign set_req    = take && (req_op == OP_SET);
   assign start_seq  = take && (req_op == OP_SEQ);
   assign start_xfer = start_seq || (take && req_op == OP_RAND);
   assign running    = (st_q == ST_RUN);
   assign acc_cyc    = running && !any_need;

   sram_ctx_file #(.ADDR_W(ADDR_W), .N_CTX(N_CTX), .CTX_W(CTX_W)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_req),
      .set_ctx  (req_ctx),
      .set_addr (req_addr),
      .upd_en   (acc_cyc && seq_q),
      .upd_ctx  (ctx_q),
      .upd_addr (cur_q + ADDR_W'(1)),
      .clr_en   (start_seq),
      .rd_ctx   (req_ctx),
      .rd_addr  (ctx_addr),
      .rd_force (ctx_force)
   );

   sram_addr_map #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .N_LAT(N_LAT)) u_map (
      .addr     (cur_q),
      .lat_flat (want),
      .chip     (chip)
   );

   sram_latch_shadow #(.LAT_W(LAT_W), .N_LAT(N_LAT)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want),
      .inval    (start_seq && ctx_force),
      .ld_en    (running),
      .ld_pick  (ld_pick),
      .any_need (any_need)
   );

   always_comb begin
      rbuf_nx = rbuf_q;
      rbuf_nx[int'(cnt_q)*8 +: 8] = sram_din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         seq_q    <= 1'b0;
         wr_q     <= 1'b0;
         ctx_q    <= '0;
         cur_q    <= '0;
         cnt_q    <= '0;
         last_q   <= '0;
         wd_q     <= '0;
         rbuf_q   <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (start_xfer) begin
            st_q   <= ST_RUN;
            seq_q  <= (req_op == OP_SEQ);
            wr_q   <= req_wr;
            ctx_q  <= req_ctx;
            cur_q  <= (req_op == OP_SEQ) ? ctx_addr : req_addr;
            cnt_q  <= '0;
            last_q <= last_of(req_size);
            wd_q   <= req_wdata;
            rbuf_q <= '0;
         end else if (acc_cyc) begin
            cur_q <= cur_q + ADDR_W'(1);
            cnt_q <= cnt_q + CNT_W'(1);
            if (!wr_q) rbuf_q <= rbuf_nx;
            if (cnt_q == last_q) begin
               st_q     <= ST_IDLE;
               rd_valid <= !wr_q;
               rd_data  <= rbuf_nx;
            end
         end
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign lat_ld    = running ? ld_pick : '0;

   always_comb begin
      lat_data = '0;
      for (int i = 0; i < N_LAT; i++) begin
         if (lat_ld[i]) lat_data = want[i*LAT_W +: LAT_W];
      end
   end

   assign sram_ce_n    = acc_cyc ? (chip ? 2'b01 : 2'b10) : 2'b11;
   assign sram_oe_n    = !(acc_cyc && !wr_q);
   assign sram_we_n    = !(acc_cyc && wr_q);
   assign sram_dout_en = acc_cyc && wr_q;
   assign sram_dout    = sram_dout_en ? wd_q[int'(cnt_q)*8 +: 8] : 8'h00;

   assert_one_chip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_oe_n || !sram_we_n) |-> ($countones(~sram_ce_n) == 1));
   assert_strobe_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_ld != '0) |-> (sram_ce_n == 2'b11 && sram_oe_n && sram_we_n));
   assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lat_ld));
   assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_oe_n && !sram_we_n));
   assert_rdv_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!sram_oe_n));
   assert_rdv_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((lat_ld != '0) || !sram_oe_n || !sram_we_n) |-> !req_ready);
endmodule

// File: tb/tb_sram_latch_seq.sv
`timescale 1ns/1ps
module tb_sram_latch_seq;
   localparam int AMASK = 32'hFFFFF;
   localparam logic [24:0] IDLE_V = {1'b1, 3'b000, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 8'h00};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_ctx = '0;
   logic [1:0]  req_op = '0;
   logic        req_wr = 1'b0;
   logic [1:0]  req_size = '0;
   logic [19:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [7:0]  lat_data;
   logic [2:0]  lat_ld;
   logic [1:0]  sram_ce_n;
   logic        sram_oe_n, sram_we_n, sram_dout_en;
   logic [7:0]  sram_dout;
   logic [7:0]  sram_din = '0;

   always #10 clk = ~clk;

   sram_latch_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctx(req_ctx), .req_op(req_op), .req_wr(req_wr), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .lat_data(lat_data), .lat_ld(lat_ld),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_dout(sram_dout), .sram_dout_en(sram_dout_en), .sram_din(sram_din)
   );

   logic [7:0]  mmem [int];
   logic [7:0]  smem [int];
   int          sh [3];
   bit          shv [3];
   int          ctxa [4];
   bit          frc [4];
   logic [7:0]  ext [3];
   int          nvec = 0;
   int          nbad = 0;
   bit          pend = 1'b0;
   logic [31:0] pend_data = '0;

   function automatic logic [7:0] mget(input int a);
      return mmem.exists(a) ? mmem[a] : 8'h00;
   endfunction

   task automatic step(input string tag, input logic [24:0] expv);
      logic [24:0] got;
      int key;
      got = {req_ready, lat_ld, lat_data, sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en, sram_dout};
      nvec++;
      if (got !== expv) begin
         nbad++;
         $display("FAIL %s pins: actual %h expected %h", tag, got, expv);
      end
      nvec++;
      if (rd_valid !== pend || (pend && rd_data !== pend_data)) begin
         nbad++;
         $display("FAIL R10 read return: actual v=%b d=%h expected v=%b d=%h",
                  rd_valid, rd_data, pend, pend_data);
      end
      pend = 1'b0;
      for (int i = 0; i < 3; i++) if (lat_ld[i]) ext[i] = lat_data;
      key = ((sram_ce_n == 2'b01) ? (1 << 19) : 0) | (int'(ext[2][2:0]) << 16)
            | (int'(ext[1]) << 8) | int'(ext[0]);
      if (!sram_we_n) smem[key] = sram_dout;
      if (!sram_oe_n) sram_din = smem.exists(key) ? smem[key] : 8'h00;
      else            sram_din = 8'h00;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step("R13 idle", IDLE_V);
   endtask

   task automatic do_op(input string tag, input int c, input logic [1:0] op,
                        input bit wr, input logic [1:0] sz, input int addr,
                        input logic [31:0] wd);
      int a, n;
      int w [3];
      logic [31:0] rd;
      logic [7:0]  b;
      req_ctx = 2'(c); req_op = op; req_wr = wr; req_size = sz;
      req_addr = 20'(addr); req_wdata = wd; req_valid = 1'b1;
      step({tag, " R12 accept"}, IDLE_V);
      req_valid = 1'b0;
      if (op == 2'd0) begin
         ctxa[c] = addr & AMASK;
         frc[c] = 1'b1;
      end else if (op == 2'd1 || op == 2'd2) begin
         a = (op == 2'd2) ? ctxa[c] : (addr & AMASK);
         if (op == 2'd2 && frc[c]) begin
            for (int i = 0; i < 3; i++) shv[i] = 1'b0;
            frc[c] = 1'b0;
         end
         n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
         rd = '0;
         for (int k = 0; k < n; k++) begin
            w[0] = a & 8'hFF; w[1] = (a >> 8) & 8'hFF; w[2] = (a >> 16) & 7;
            for (int i = 0; i < 3; i++) begin
               if (!shv[i] || sh[i] != w[i]) begin
                  step({tag, " R3 load"}, {1'b0, 3'(1 << i), 8'(w[i]), 2'b11, 1'b1, 1'b1, 1'b0, 8'h00});
                  sh[i] = w[i];
                  shv[i] = 1'b1;
               end
            end
            b = wd[8*k +: 8];
            step({tag, " R2 R9 access"}, {1'b0, 3'b000, 8'h00,
                  ((a >> 19) & 1) ? 2'b01 : 2'b10, wr, !wr, wr, wr ? b : 8'h00});
            if (wr) mmem[a] = b;
            else    rd[8*k +: 8] = mget(a);
            a = (a + 1) & AMASK;
            if (op == 2'd2) ctxa[c] = a;
         end
         if (!wr) begin
            pend = 1'b1;
            pend_data = rd;
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin ctxa[i] = 0; frc[i] = 1'b1; end
      for (int i = 0; i < 3; i++) begin sh[i] = 0; shv[i] = 1'b0; ext[i] = 8'h00; end
      @(negedge clk);
      step("R1 in reset", IDLE_V);
      step("R1 in reset", IDLE_V);
      rst_n = 1'b1;
      step("R1 after reset", IDLE_V);
      // cold latches: all three loaded, then only low byte changes (R3, R8, R9)
      do_op("R3 R8", 0, 2'd1, 1'b1, 2'd2, 32'h12345, 32'hA1B2C3D4);
      do_op("R3 R10", 0, 2'd1, 1'b0, 2'd2, 32'h12345, 32'h0);
      // stream across the chip boundary (R2, R5)
      do_op("R4", 1, 2'd0, 1'b0, 2'd0, 32'h7FFFE, 32'h0);
      do_op("R2 R5", 1, 2'd1 + 2'd1, 1'b1, 2'd2, 0, 32'h11223344);
      // interleaved contexts (R6)
      do_op("R4", 2, 2'd0, 1'b0, 2'd0, 32'h00100, 32'h0);
      do_op("R6", 2, 2'd2, 1'b1, 2'd1, 0, 32'h0000BEEF);
      do_op("R6", 1, 2'd2, 1'b0, 2'd0, 0, 32'h0);
      do_op("R6", 2, 2'd2, 1'b1, 2'd1, 0, 32'h00005A6B);
      do_op("R4", 2, 2'd0, 1'b0, 2'd0, 32'h00100, 32'h0);
      do_op("R6 R8", 2, 2'd2, 1'b0, 2'd2, 0, 32'h0);
      do_op("R4", 1, 2'd0, 1'b0, 2'd0, 32'h7FFFE, 32'h0);
      do_op("R2 R4", 1, 2'd2, 1'b0, 2'd2, 0, 32'h0);
      // set onto matching latch values still forces a full reload (R4)
      do_op("R7", 0, 2'd1, 1'b1, 2'd0, 32'h00500, 32'h000000C3);
      do_op("R4", 3, 2'd0, 1'b0, 2'd0, 32'h00501, 32'h0);
      do_op("R4", 3, 2'd2, 1'b1, 2'd0, 0, 32'h0000003C);
      // random access does not move a context (R7)
      do_op("R7", 0, 2'd1, 1'b1, 2'd0, 32'h40000, 32'h0000005A);
      do_op("R7", 3, 2'd2, 1'b1, 2'd0, 0, 32'h00000077);
      // no-op changes nothing (R11)
      do_op("R11", 3, 2'd3, 1'b1, 2'd2, 32'hFFFFF, 32'hFFFFFFFF);
      do_op("R11", 3, 2'd2, 1'b0, 2'd0, 0, 32'h0);
      do_op("R11", 0, 2'd1, 1'b0, 2'd2, 32'h00500, 32'h0);
      // wrap at the top of the space, size 3 moves four bytes (R5, R8)
      do_op("R5", 0, 2'd0, 1'b0, 2'd0, 32'hFFFFE, 32'h0);
      do_op("R5 R8", 0, 2'd2, 1'b1, 2'd3, 0, 32'hCAFEF00D);
      do_op("R5", 0, 2'd1, 1'b0, 2'd2, 32'hFFFFE, 32'h0);
      do_op("R10", 0, 2'd1, 1'b0, 2'd1, 32'h00000, 32'h0);
      do_op("R10", 1, 2'd1, 1'b0, 2'd0, 32'h80001, 32'h0);
      idle(3);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule